// File: doc/BRIEF.md
# Flash page program sequencer

This block runs one program cycle on a 128-byte page of an on-chip flash array. A host asks for a cycle by pulsing a start request with a page address. The global flash write-enable must be high and the page address must be page-aligned, or the request is refused. Once a request is accepted, the block raises the array write enable and fills its page buffer with the erased value 0xFF. After a settling delay it opens a load window. During the window the host writes bytes by offset. When the host closes the window, the block latches the pulse width and arms an overprogramming watchdog. It then steps the array strobes through setup, program pulse and teardown.

Every delay is a cycle count, and each one is a parameter derived from the clock frequency. The program pulse width comes from an input. The watchdog covers the time from arming until the end of teardown. If it runs out first, the block drops the setup and program strobes at once and flags an abort.

Top module: `fpp_seq`

## Requirements
- R1: A start request made while idle with `fwe_i` low is refused: `err_o` goes high on the next cycle and `busy_o` stays low.
- R2: A start request whose address has a nonzero value in bits [6:0] (low byte not 0x00 or 0x80) is refused and sets `err_o`. An accepted request clears `err_o` and latches the address onto `page_addr_o`.
- R3: An accepted start sets all 128 buffer bytes to 0xFF. Byte k of the page appears on `page_data_o[8k+7:8k]`, and after reset every byte is 0xFF.
- R4: `swe_o` goes high in the cycle after an accepted start. The load window opens only after `swe_o` has been high for T_WE_CYC cycles.
- R5: The watchdog is armed when the load window closes. If T_WDT_CYC cycles pass before teardown ends, `psu_o` and `prog_o` drop together, the cycle ends and `wdt_abort_o` sets, staying high until the next accepted start. When expiry and normal completion fall in the same cycle, the abort wins.
- R6: `psu_o` rises in the cycle after `load_done_i` and stays high alone for T_PSU_CYC cycles. `prog_o` is then high for the number of cycles in `pulse_w_i`, sampled with `load_done_i`; a width of 0 is treated as 1.
- R7: Teardown drops `prog_o` first. `psu_o` stays high for T_CP_CYC more cycles, then `swe_o` stays high for T_CPSU_CYC more cycles.
- R8: `busy_o` equals `swe_o`. `done_o` is a one-cycle pulse in the first idle cycle after every accepted cycle, whether it ended normally or by abort.
- R9: A byte write outside the load window leaves the buffer unchanged and sets the sticky `proto_err_o`. An accepted start clears the flag, but a stray write in that same cycle keeps it set.
- R10: A start request made while busy is ignored: the address, the strobes and the flags are unchanged.
- R11: Inside the load window, a byte write stores `byte_data_i` at `byte_off_i`. A write in the same cycle as `load_done_i` is still stored, and a later write to the same offset overwrites the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwe_i | input | 1 | Global flash write permission |
| start_i | input | 1 | Request a program cycle |
| addr_i | input | AW | Page start address |
| pulse_w_i | input | PW_W | Program pulse width in cycles |
| byte_we_i | input | 1 | Byte write strobe |
| byte_off_i | input | log2(PAGE_BYTES) | Byte offset within the page |
| byte_data_i | input | 8 | Byte value |
| load_done_i | input | 1 | Close the load window and begin programming |
| swe_o | output | 1 | Array write enable |
| psu_o | output | 1 | Program setup strobe |
| prog_o | output | 1 | Program pulse strobe |
| page_addr_o | output | AW | Latched page address |
| page_data_o | output | 8*PAGE_BYTES | Page buffer contents |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | End-of-cycle pulse |
| err_o | output | 1 | Last request refused |
| proto_err_o | output | 1 | Sticky stray-write flag |
| wdt_abort_o | output | 1 | Sticky watchdog abort flag |

## Verification
Watchdog expiry and normal teardown completion can fall on the same clock edge. The bench provokes this by choosing a pulse width that makes setup, pulse and both teardown delays add up to exactly the watchdog period. It then expects the abort flag and a single done pulse. A second pair of events that can coincide is the last byte write and the closing of the load window; the bench issues both together and expects the byte to land. A behavioural model, compared on every clock, judges both cases.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WEN, ST_LOAD, ST_SETUP, ST_PULSE, ST_HOLD, ST_RECOV
  } fpp_state_e;
endpackage

// File: rtl/fpp_page_buf.sv
module fpp_page_buf #(
  parameter int unsigned NB = 128
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fill_i,
  input  logic                      we_i,
  input  logic [$clog2(NB)-1:0]     off_i,
  input  logic [7:0]                data_i,
  output logic [NB*8-1:0]           data_o
);
  localparam int unsigned OW = $clog2(NB);

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= 8'hFF;
      else if (fill_i)                          q <= 8'hFF;
      else if (we_i && off_i == OW'(i))         q <= data_i;
    end
    assign data_o[8*i +: 8] = q;
  end
endmodule

// File: rtl/fpp_dly.sv
module fpp_dly #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (ld_i)         cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

  AST_DLY_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !ld_i) |=> zero_o);  // R6
endmodule

// File: rtl/fpp_wdt.sv
module fpp_wdt #(
  parameter int unsigned LIM = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic stop_i,
  output logic expire_o
);
  localparam int unsigned W = $clog2(LIM + 1);
  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign expire_o = run_q && (cnt_q == W'(LIM - 1));

  AST_WDT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q <= W'(LIM - 1)));  // R5
endmodule

// File: rtl/fpp_seq.sv
module fpp_seq
  import fpp_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 125,
  parameter int unsigned AW         = 16,
  parameter int unsigned PW_W       = 16,
  parameter int unsigned PAGE_BYTES = 128,
  parameter int unsigned T_WE_CYC   = 10 * CLK_MHZ,
  parameter int unsigned T_PSU_CYC  = 50 * CLK_MHZ,
  parameter int unsigned T_CP_CYC   = 5 * CLK_MHZ,
  parameter int unsigned T_CPSU_CYC = 5 * CLK_MHZ,
  parameter int unsigned T_WDT_CYC  = 6600 * CLK_MHZ
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          fwe_i,
  input  logic                          start_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [PW_W-1:0]               pulse_w_i,
  input  logic                          byte_we_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] byte_off_i,
  input  logic [7:0]                    byte_data_i,
  input  logic                          load_done_i,
  output logic                          swe_o,
  output logic                          psu_o,
  output logic                          prog_o,
  output logic [AW-1:0]                 page_addr_o,
  output logic [PAGE_BYTES*8-1:0]       page_data_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          err_o,
  output logic                          proto_err_o,
  output logic                          wdt_abort_o
);
  localparam int unsigned OW    = $clog2(PAGE_BYTES);
  localparam int unsigned MAX_A = (T_WE_CYC > T_PSU_CYC) ? T_WE_CYC : T_PSU_CYC;
  localparam int unsigned MAX_B = (T_CP_CYC > T_CPSU_CYC) ? T_CP_CYC : T_CPSU_CYC;
  localparam int unsigned MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned DW    = $clog2(MAX_D + 1);
  localparam int unsigned TW    = (DW > PW_W) ? DW : PW_W;

  fpp_state_e      st_q, st_d;
  logic            tmr_ld, tmr_zero, wdt_arm, wdt_stop, wdt_exp, fin;
  logic [TW-1:0]   tmr_val;
  logic [PW_W-1:0] pw_q;
  logic            err_q, proto_q, abort_q, done_q;
  logic [AW-1:0]   addr_q;
  logic            start_ok, start_bad, in_load;

  assign in_load   = (st_q == ST_LOAD);
  assign start_ok  = (st_q == ST_IDLE) && start_i && fwe_i && (addr_i[OW-1:0] == '0);
  assign start_bad = (st_q == ST_IDLE) && start_i && !start_ok;

  always_comb begin
    st_d     = st_q;
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    wdt_arm  = 1'b0;
    wdt_stop = 1'b0;
    fin      = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (start_ok) begin
                  st_d = ST_WEN; tmr_ld = 1'b1; tmr_val = TW'(T_WE_CYC - 1);
                end
      ST_WEN:   if (tmr_zero) st_d = ST_LOAD;
      ST_LOAD:  if (load_done_i) begin
                  st_d = ST_SETUP; tmr_ld = 1'b1; tmr_val = TW'(T_PSU_CYC - 1);
                  wdt_arm = 1'b1;
                end
      ST_SETUP: if (tmr_zero) begin
                  st_d = ST_PULSE; tmr_ld = 1'b1;
                  tmr_val = (pw_q == '0) ? '0 : TW'(pw_q) - TW'(1);  // width 0 acts as 1
                end
      ST_PULSE: if (tmr_zero) begin
                  st_d = ST_HOLD; tmr_ld = 1'b1; tmr_val = TW'(T_CP_CYC - 1);
                end
      ST_HOLD:  if (tmr_zero) begin
                  st_d = ST_RECOV; tmr_ld = 1'b1; tmr_val = TW'(T_CPSU_CYC - 1);
                end
      ST_RECOV: if (tmr_zero) begin
                  st_d = ST_IDLE; wdt_stop = 1'b1; fin = 1'b1;
                end
      default:  st_d = ST_IDLE;
    endcase
    // expiry overrides any normal step, including completion in the same cycle
    if (wdt_exp) begin
      st_d     = ST_IDLE;
      wdt_stop = 1'b1;
      fin      = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      pw_q    <= '0;
      addr_q  <= '0;
      err_q   <= 1'b0;
      proto_q <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (in_load && load_done_i) pw_q <= pulse_w_i;
      if (start_ok) addr_q <= addr_i;
      if (start_bad)     err_q <= 1'b1;
      else if (start_ok) err_q <= 1'b0;
      if (byte_we_i && !in_load) proto_q <= 1'b1;  // set beats clear
      else if (start_ok)         proto_q <= 1'b0;
      if (wdt_exp)       abort_q <= 1'b1;
      else if (start_ok) abort_q <= 1'b0;
    end
  end

  fpp_dly #(.W(TW)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (tmr_ld),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  fpp_wdt #(.LIM(T_WDT_CYC)) u_wdt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (wdt_arm),
    .stop_i   (wdt_stop),
    .expire_o (wdt_exp)
  );

  fpp_page_buf #(.NB(PAGE_BYTES)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fill_i (start_ok),
    .we_i   (byte_we_i && in_load),
    .off_i  (byte_off_i),
    .data_i (byte_data_i),
    .data_o (page_data_o)
  );

  assign swe_o       = (st_q != ST_IDLE);
  assign psu_o       = (st_q == ST_SETUP) || (st_q == ST_PULSE) || (st_q == ST_HOLD);
  assign prog_o      = (st_q == ST_PULSE);
  assign busy_o      = swe_o;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign proto_err_o = proto_q;
  assign wdt_abort_o = abort_q;
  assign page_addr_o = addr_q;

  AST_PROG_NEEDS_PSU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> psu_o);  // R6
  AST_PSU_NEEDS_SWE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psu_o |-> swe_o);  // R7
  AST_PROG_AFTER_PSU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_o) |-> $past(psu_o));  // R6
  AST_PROG_DROPS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(psu_o) && !wdt_abort_o) |-> !$past(prog_o));  // R7
  AST_SWE_DROPS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(swe_o) && !wdt_abort_o) |-> !$past(psu_o));  // R7
  AST_ABORT_KILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_abort_o) |-> (!prog_o && !psu_o));  // R5
  AST_PAGE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (page_addr_o[OW-1:0] == '0));  // R2
  AST_START_NEEDS_FWE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(fwe_i));  // R1
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);  // R8
endmodule

// File: tb/fpp_seq_bench.sv
module fpp_seq_bench;
  localparam int T_WE = 5, T_PSU = 3, T_CP = 2, T_CPSU = 2, WDT = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic         fwe = 1'b0, start = 1'b0, bwe = 1'b0, ldone = 1'b0;
  logic [15:0]  addr = '0, pw = '0;
  logic [6:0]   boff = '0;
  logic [7:0]   bdat = '0;
  logic         swe, psu, prog, busy, done, err, perr, abrt;
  logic [15:0]  paddr;
  logic [1023:0] pdata;

  fpp_seq #(.T_WE_CYC(T_WE), .T_PSU_CYC(T_PSU), .T_CP_CYC(T_CP),
            .T_CPSU_CYC(T_CPSU), .T_WDT_CYC(WDT)) u_fpp_seq (
    .clk_i(clk), .rst_ni(rst_n), .fwe_i(fwe), .start_i(start), .addr_i(addr),
    .pulse_w_i(pw), .byte_we_i(bwe), .byte_off_i(boff), .byte_data_i(bdat),
    .load_done_i(ldone), .swe_o(swe), .psu_o(psu), .prog_o(prog),
    .page_addr_o(paddr), .page_data_o(pdata), .busy_o(busy), .done_o(done),
    .err_o(err), .proto_err_o(perr), .wdt_abort_o(abrt));

  int n_cmp = 0, n_bad = 0;

  // behavioural reference: phase 0 idle,1 enable wait,2 load,3 setup,4 pulse,5 hold,6 recover
  int m_ph, m_rem, m_wdt, m_pw;
  bit m_wrun;
  logic m_err, m_perr, m_abrt, m_done;
  logic [15:0] m_addr;
  logic [7:0] m_mem[128];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_rem = 0; m_wdt = 0; m_pw = 1; m_wrun = 0;
      m_err = 0; m_perr = 0; m_abrt = 0; m_done = 0; m_addr = '0;
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
    end else begin
      int p;
      bit ok;
      p = m_ph;
      m_done = 0;
      ok = (p == 0) && start && fwe && (addr[6:0] == 0);
      if (p == 0 && start && !ok) m_err = 1;
      if (ok) begin
        m_err = 0; m_perr = 0; m_abrt = 0; m_addr = addr;
        foreach (m_mem[i]) m_mem[i] = 8'hFF;
      end
      if (bwe) begin
        if (p == 2) m_mem[boff] = bdat;
        else m_perr = 1;
      end
      if (m_wrun && m_wdt == WDT - 1) begin
        m_abrt = 1; m_ph = 0; m_done = 1; m_wrun = 0;
      end else begin
        if (m_wrun) m_wdt++;
        case (p)
          0: if (ok) begin m_ph = 1; m_rem = T_WE; end
          1: if (m_rem == 1) m_ph = 2; else m_rem--;
          2: if (ldone) begin
               m_ph = 3; m_rem = T_PSU; m_pw = (pw == 0) ? 1 : int'(pw);
               m_wrun = 1; m_wdt = 0;
             end
          3: if (m_rem == 1) begin m_ph = 4; m_rem = m_pw; end else m_rem--;
          4: if (m_rem == 1) begin m_ph = 5; m_rem = T_CP; end else m_rem--;
          5: if (m_rem == 1) begin m_ph = 6; m_rem = T_CPSU; end else m_rem--;
          6: if (m_rem == 1) begin m_ph = 0; m_done = 1; m_wrun = 0; end else m_rem--;
          default: m_ph = 0;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [1023:0] act, logic [1023:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [1023:0] v;
    foreach (m_mem[i]) v[8*i +: 8] = m_mem[i];
    chk("R4,R7 swe",   1024'(swe),  1024'(m_ph != 0));
    chk("R6,R7 psu",   1024'(psu),  1024'(m_ph inside {3, 4, 5}));
    chk("R6 prog",     1024'(prog), 1024'(m_ph == 4));
    chk("R8 busy",     1024'(busy), 1024'(m_ph != 0));
    chk("R8 done",     1024'(done), 1024'(m_done));
    chk("R1,R2 err",   1024'(err),  1024'(m_err));
    chk("R9 proto",    1024'(perr), 1024'(m_perr));
    chk("R5 abort",    1024'(abrt), 1024'(m_abrt));
    chk("R2 addr",     1024'(paddr), 1024'(m_addr));
    chk("R3,R11 data", pdata, v);
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(logic [15:0] a, logic f);
    addr = a; fwe = f; start = 1'b1; tick(); start = 1'b0;
  endtask

  task automatic wr(int o, logic [7:0] d);
    boff = 7'(o); bdat = d; bwe = 1'b1; tick(); bwe = 1'b0;
  endtask

  task automatic wait_ph(int p);
    while (m_ph != p) tick();
  endtask

  task automatic close(logic [15:0] w);
    pw = w; ldone = 1'b1; tick(); ldone = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        n_bad++; n_cmp++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(2);           // reset state, all 0xFF (R3)
    go(16'h1200, 1'b0); tick(3);              // R1 refused, no write permission
    go(16'h1241, 1'b1); tick(3);              // R2 misaligned
    go(16'h1280, 1'b1);                       // accepted, R4 wait window
    wr(3, 8'h77);                             // R9 write before window
    wait_ph(2);
    for (int i = 0; i < 10; i++) wr(i, 8'(i * 17 + 1));
    wr(5, 8'hC3);                             // R11 overwrite
    boff = 7'd127; bdat = 8'h5A; bwe = 1'b1;  // R11 write with window close
    close(16'd4); bwe = 1'b0;
    wait_ph(0); tick(3);
    go(16'h3400, 1'b1); wait_ph(2);
    close(16'd0);                             // R6 zero width acts as one
    go(16'h5500, 1'b1); tick();               // R10 request while busy
    chk("R10 addr kept", 1024'(paddr), 1024'(16'h3400));
    wait_ph(0); tick(2);
    go(16'h0080, 1'b1); wait_ph(2);
    close(16'd13);                            // R5 expiry meets completion
    wait_ph(0); tick(2);
    go(16'h0100, 1'b1); wait_ph(2);
    close(16'd30);                            // R5 expiry mid pulse
    wait_ph(4); wr(9, 8'h11);                 // R9 write during pulse
    wait_ph(0); tick(2);
    fwe = 1'b1; bwe = 1'b1; boff = 7'd1;      // R9 stray write with accepted start
    go(16'h0180, 1'b1); bwe = 1'b0;
    wait_ph(2); close(16'd2);
    wait_ph(0); tick(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule